// File: doc/BRIEF.md
# Single-wire consumer-control bus receiver with acknowledge driver

This block listens to a single-wire, open-drain consumer-control bus and turns the pulse-width-coded bits on it into bytes. The transmitter starts every bit by pulling the line low. A short low phase stands for a 1 and a long low phase stands for a 0. The receiver synchronises the line, finds each falling edge and counts sampling ticks from that edge. It then reads the line at a sample point that software can move. A long low pulse marks the start of a message. After it, the first 10-bit block is the header and every later block is a data block.

Each block carries 8 data bits MSB first, then an end-of-message (EOM) bit, then an acknowledge slot. The low nibble of the header byte is the destination address. The block compares it with a programmed logical address. When the address matches, the receiver acknowledges by holding the line low through the acknowledge slot, which makes the slot read as 0:

- For a header, the match alone is enough.
- For a data block, a configuration input can suppress the acknowledge.

All timing is counted in sampling ticks, given by an enable input, and every threshold is a parameter.

Top module: `cec_rx_ack`

## Requirements
- R1: While rst_ni is low and right after its release, cec_pull_o and rx_valid_o are 0.
- R2: A bit reads 0 if the synchronised line is low at the sample point and 1 if it is high. The sample point lies REF_TICKS + 2*ofs ticks after the falling edge. ofs is sample_ofs_i read as 3-bit two's complement. The value -4 is treated as -3, so the shift covers -6 to +6 ticks.
- R3: A low phase lasting START_TICKS ticks starts a message, and the next block is the header. Bits that arrive before any start are ignored. A start in the middle of a block discards that partial block.
- R4: A block is 8 data bits MSB first, then the EOM bit, then the acknowledge slot. When the EOM bit is sampled, rx_valid_o pulses high for one clock. In that clock rx_byte_o holds the byte and rx_eom_o holds the EOM value.
- R5: A header whose low nibble equals log_addr_i is acknowledged whatever the value of data_ack_off_i.
- R6: Address-match state is kept from the header for the rest of the message. A data block of a matched message is acknowledged when data_ack_off_i is 0 and left unacknowledged when it is 1. data_ack_off_i is read when the EOM bit is sampled.
- R7: When the header address does not match, cec_pull_o is never asserted for the header or for any data block of that message.
- R8: An acknowledge asserts cec_pull_o within 4 clocks of the slot's falling edge on cec_i. It holds cec_pull_o for ACK_LOW_TICKS ticks (plus at most one). cec_pull_o is never high outside an acknowledge slot.
- R9: Once a block with EOM = 1 has had its acknowledge slot, later blocks are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sampling tick enable, one clock wide |
| cec_i | input | 1 | Bus line level (asynchronous) |
| log_addr_i | input | 4 | Programmed logical address |
| sample_ofs_i | input | 3 | Signed sample-point shift in two-tick steps |
| data_ack_off_i | input | 1 | 1 = do not acknowledge data blocks |
| cec_pull_o | output | 1 | Open-drain pull-low enable |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock strobe for rx_byte_o and rx_eom_o |
| rx_eom_o | output | 1 | EOM bit of the last received block |

## Verification
A corrupt bit index or a wrong header flag shows at the ports within a single block in one of two ways: the strobe lands on the wrong bit, or an acknowledge is driven for a block that should be silent. The bench compares the pull-low output against its own picture of the acknowledge slots on every clock, so a stray pull is reported in the clock where it appears. A misplaced sample point only shows on a bit whose low phase ends between the nominal and the shifted point. For that reason the offset cases use low times placed a few ticks either side of the expected point. Match state that leaks past a message, or is lost between blocks, shows up in the acknowledge of the very next data block.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = 4;
  localparam logic [BIT_IDX_W-1:0] IDX_EOM = BIT_IDX_W'(BYTE_W);
  localparam logic [BIT_IDX_W-1:0] IDX_ACK = BIT_IDX_W'(BYTE_W + 1);
  localparam int OFS_STEP  = 2;

  typedef logic [BYTE_W-1:0] rx_byte_t;
endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/cec_rx_bit.sv
module cec_rx_bit import cec_rx_pkg::*; #(
  parameter int REF_TICKS   = 21,
  parameter int START_TICKS = 70,
  parameter int OFS_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             bit_vld_o,
  output logic             bit_val_o,
  output logic             start_o
);
  localparam int CNT_W = $clog2(START_TICKS + 1);
  localparam logic [CNT_W-1:0] START_CNT = CNT_W'(START_TICKS);

  logic signed [OFS_W-1:0] ofs_s;
  int                      ofs_c;
  logic [CNT_W-1:0]        sp_cnt;
  logic [CNT_W-1:0]        cnt_q, cnt_nxt;
  logic                    act_q, step;

  // most negative code folds onto its neighbour: symmetric range
  always_comb begin
    ofs_s = signed'(ofs_i);
    ofs_c = int'(ofs_s);
    if (ofs_c == -(2 ** (OFS_W - 1))) ofs_c = ofs_c + 1;
    sp_cnt = CNT_W'(REF_TICKS + OFS_STEP * ofs_c);
  end

  assign cnt_nxt = cnt_q + 1'b1;
  assign step    = tick_i & act_q & ~fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_q     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_val_o <= 1'b1;
      start_o   <= 1'b0;
    end else begin
      bit_vld_o <= step && (cnt_nxt == sp_cnt);
      start_o   <= step && !line_i && (cnt_nxt == START_CNT);
      if (step && cnt_nxt == sp_cnt) bit_val_o <= line_i;
      if (fall_i) begin
        cnt_q <= '0;
        act_q <= 1'b1;
      end else if (step) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt == START_CNT) act_q <= 1'b0;
      end
    end
  end

  a_r2_sample_not_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_vld_o && start_o));
endmodule

// File: rtl/cec_rx_frame.sv
module cec_rx_frame import cec_rx_pkg::*; #(
  parameter int ACK_LOW_TICKS = 30,
  parameter int AW            = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic          bit_vld_i,
  input  logic          bit_val_i,
  input  logic          start_i,
  input  logic [AW-1:0] log_addr_i,
  input  logic          data_ack_off_i,
  output logic          pull_o,
  output rx_byte_t      byte_o,
  output logic          valid_o,
  output logic          eom_o
);
  localparam int ACNT_W = $clog2(ACK_LOW_TICKS + 1);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ACK_LOW_TICKS - 1);

  logic [BIT_IDX_W-1:0] idx_q;
  rx_byte_t             sh_q, sh_nxt;
  logic                 in_msg_q, hdr_q, match_q, arm_q;
  logic                 drive_q;
  logic [ACNT_W-1:0]    acnt_q;

  assign sh_nxt = {sh_q[BYTE_W-2:0], bit_val_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      sh_q     <= '0;
      in_msg_q <= 1'b0;
      hdr_q    <= 1'b0;
      match_q  <= 1'b0;
      arm_q    <= 1'b0;
      byte_o   <= '0;
      valid_o  <= 1'b0;
      eom_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        in_msg_q <= 1'b1;
        hdr_q    <= 1'b1;
        idx_q    <= '0;
        arm_q    <= 1'b0;
        match_q  <= 1'b0;
      end else if (bit_vld_i && in_msg_q) begin
        if (idx_q < IDX_EOM) begin
          sh_q  <= sh_nxt;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_EOM - 1'b1 && hdr_q)
            match_q <= (sh_nxt[AW-1:0] == log_addr_i);
        end else if (idx_q == IDX_EOM) begin
          byte_o  <= sh_q;
          eom_o   <= bit_val_i;
          valid_o <= 1'b1;
          arm_q   <= match_q && (hdr_q || !data_ack_off_i);
          idx_q   <= IDX_ACK;
        end else begin
          idx_q <= '0;
          hdr_q <= 1'b0;
          arm_q <= 1'b0;
          if (eom_o) in_msg_q <= 1'b0;
        end
      end
    end
  end

  // ack pull-low: starts on the slot's falling edge, lasts a logical-0 low time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      acnt_q  <= '0;
    end else if (fall_i && arm_q && idx_q == IDX_ACK) begin
      drive_q <= 1'b1;
      acnt_q  <= '0;
    end else if (drive_q && tick_i) begin
      if (acnt_q == ACNT_LAST) drive_q <= 1'b0;
      else acnt_q <= acnt_q + 1'b1;
    end
  end

  assign pull_o = drive_q;

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r7_pull_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> match_q);
  a_r8_ack_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> acnt_q <= ACNT_LAST);
  a_r3_start_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_q == '0 && hdr_q && in_msg_q));
endmodule

// File: rtl/cec_rx_ack.sv
module cec_rx_ack import cec_rx_pkg::*; #(
  parameter int REF_TICKS     = 21,
  parameter int START_TICKS   = 70,
  parameter int ACK_LOW_TICKS = 30,
  parameter int OFS_W         = 3,
  parameter int AW            = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cec_i,
  input  logic [AW-1:0]    log_addr_i,
  input  logic [OFS_W-1:0] sample_ofs_i,
  input  logic             data_ack_off_i,
  output logic             cec_pull_o,
  output logic [7:0]       rx_byte_o,
  output logic             rx_valid_o,
  output logic             rx_eom_o
);
  logic line_s, fall_s, bit_vld, bit_val, start_p;

  cec_rx_sync u_sync (
    .clk_i, .rst_ni, .line_i(cec_i), .line_o(line_s), .fall_o(fall_s)
  );

  cec_rx_bit #(
    .REF_TICKS(REF_TICKS), .START_TICKS(START_TICKS), .OFS_W(OFS_W)
  ) u_bit (
    .clk_i, .rst_ni, .tick_i, .line_i(line_s), .fall_i(fall_s),
    .ofs_i(sample_ofs_i), .bit_vld_o(bit_vld), .bit_val_o(bit_val),
    .start_o(start_p)
  );

  cec_rx_frame #(.ACK_LOW_TICKS(ACK_LOW_TICKS), .AW(AW)) u_frame (
    .clk_i, .rst_ni, .tick_i, .fall_i(fall_s), .bit_vld_i(bit_vld),
    .bit_val_i(bit_val), .start_i(start_p), .log_addr_i,
    .data_ack_off_i, .pull_o(cec_pull_o), .byte_o(rx_byte_o),
    .valid_o(rx_valid_o), .eom_o(rx_eom_o)
  );
endmodule

// File: tb/cec_rx_ack_tb.sv
module cec_rx_ack_tb_top;
  localparam int TDIV = 4, REF = 21, STRT = 70, ACKL = 30;
  localparam int PER = 48, LOW1 = 12, LOW0 = 30, SLOW = 74, SPER = 90;

  logic clk = 0, rst_n = 0, tick = 0, tx_low = 0;
  logic [3:0] log_addr = 4'h5;
  logic [2:0] ofs = 3'd0;
  logic ack_off = 1'b0;
  logic pull, valid, eom;
  logic [7:0] rbyte;
  logic cec;
  int div = 0;
  int compared = 0, failed = 0, clk_cmp = 0, clk_fail = 0;
  int ack_ticks = 0, valid_cnt = 0;
  logic [7:0] last_byte = '0;
  logic last_eom = 0, ack_slot = 0, mon_on = 0, done = 0;

  always #5 clk = ~clk;
  assign cec = !(tx_low || pull);

  always_ff @(posedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
  end

  cec_rx_ack dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cec_i(cec),
    .log_addr_i(log_addr), .sample_ofs_i(ofs), .data_ack_off_i(ack_off),
    .cec_pull_o(pull), .rx_byte_o(rbyte), .rx_valid_o(valid), .rx_eom_o(eom)
  );

  // per-clock reference: pull only inside an ack slot the bench opened
  always @(negedge clk) if (mon_on) begin
    if (tick && ack_slot && pull) ack_ticks++;
    if (valid) begin valid_cnt++; last_byte = rbyte; last_eom = eom; end
    clk_cmp++;
    if (!ack_slot && pull) begin
      clk_fail++;
      $display("FAIL R8 pull outside ack slot at %0t: got 1 exp 0", $time);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  task automatic send_pulse(input int low, input int per);
    tx_low = 1; wait_ticks(low);
    tx_low = 0; wait_ticks(per - low);
  endtask

  task automatic send_start();
    send_pulse(SLOW, SPER);
  endtask

  function automatic int exp_sp(input logic [2:0] o);
    int v = int'($signed(o));
    if (v == -4) v = -3;
    return REF + 2 * v;
  endfunction

  // flow: 8 data bits (forced low time if flow>0), EOM, ack slot
  task automatic send_block(input logic [7:0] b, input logic e, input int flow,
                            input bit exp_rx, input logic [7:0] exp_b,
                            input bit exp_ack, input string req);
    int v0, a0;
    v0 = valid_cnt;
    for (int i = 7; i >= 0; i--)
      send_pulse(flow > 0 ? flow : (b[i] ? LOW1 : LOW0), PER);
    send_pulse(e ? LOW1 : LOW0, PER);
    a0 = ack_ticks;
    ack_slot = 1;
    send_pulse(LOW1, PER);
    ack_slot = 0;
    chk((valid_cnt - v0) == (exp_rx ? 1 : 0), {req, " strobe count"}, valid_cnt - v0, exp_rx ? 1 : 0);
    if (exp_rx) begin
      chk(last_byte == exp_b, {req, " byte"}, last_byte, exp_b);
      chk(last_eom == e, "R4 eom", last_eom, e);
    end
    if (exp_ack)
      chk((ack_ticks - a0) >= ACKL && (ack_ticks - a0) <= ACKL + 1, {req, " ack length"}, ack_ticks - a0, ACKL);
    else
      chk((ack_ticks - a0) == 0, {req, " no ack"}, ack_ticks - a0, 0);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      failed++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + clk_cmp, failed + clk_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pull == 0 && valid == 0, "R1 in reset", {pull, valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pull == 0 && valid == 0, "R1 after reset", {pull, valid}, 0);
    mon_on = 1;
    wait_ticks(10);

    // R3: no start yet, matching address must be ignored
    send_block(8'h55, 0, 0, 0, 8'h00, 0, "R3 pre-start");

    // matched message
    send_start();
    ack_off = 1;
    send_block(8'h35, 0, 0, 1, 8'h35, 1, "R5 header ack");
    ack_off = 0;
    send_block(8'hA6, 0, 0, 1, 8'hA6, 1, "R6 data ack on");
    ack_off = 1;
    send_block(8'h0F, 1, 0, 1, 8'h0F, 0, "R6 data ack off");
    ack_off = 0;
    send_block(8'h12, 0, 0, 0, 8'h00, 0, "R9 after eom");

    // partial block then restart; mismatched message
    send_start();
    for (int i = 0; i < 4; i++) send_pulse(LOW0, PER);
    send_start();
    send_block(8'h2B, 0, 0, 1, 8'h2B, 0, "R7 header mismatch");
    send_block(8'h77, 1, 0, 1, 8'h77, 0, "R7 data mismatch");

    // sample-point shifts: every data bit low 24 or 18 ticks
    log_addr = 4'hF;
    ofs = 3'd3;
    send_start();
    send_block(8'h00, 1, 24, 1, (24 < exp_sp(ofs)) ? 8'hFF : 8'h00, 1, "R2 ofs +3");
    ofs = 3'd0;
    send_start();
    send_block(8'h00, 1, 24, 1, (24 < exp_sp(ofs)) ? 8'hFF : 8'h00, 0, "R2 ofs 0 low24");
    send_start();
    send_block(8'h00, 1, 18, 1, (18 < exp_sp(ofs)) ? 8'hFF : 8'h00, 1, "R2 ofs 0 low18");
    ofs = 3'b101;
    send_start();
    send_block(8'h00, 1, 18, 1, (18 < exp_sp(ofs)) ? 8'hFF : 8'h00, 0, "R2 ofs -3");
    ofs = 3'b100;
    send_start();
    send_block(8'h00, 1, 18, 1, (18 < exp_sp(ofs)) ? 8'hFF : 8'h00, 0, "R2 ofs -4 clamp");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + clk_cmp, failed + clk_fail);
    $finish;
  end
endmodule